// File: doc/BRIEF.md
# Inter-processor doorbell register block

This block passes doorbell interrupts between the local processor and up to eleven other processor agents. Software on the local side writes a trigger register to send a single-cycle doorbell pulse to any set of agents. Doorbells arriving from the agents are latched into a status register, which software clears by writing ones. A per-channel mask can only be changed through two write-only ports. One port unmasks the channels written as one. The other port masks them. A single interrupt line goes high while any latched doorbell is unmasked.

The eleven channels do not sit at consecutive bit positions of the 32-bit bus word. They occupy bit 0, bits 8 to 9, bits 16 to 19 and bits 24 to 27. Inside the block each register holds only eleven compact lane bits. The bus logic gathers write data from the sparse positions and spreads read data back to them.

The block also takes a level from each agent that shows whether that agent still has a doorbell pending. Software can read these levels through an observation register. In the other direction, each channel has an output that tells the matching agent whether this side still holds its doorbell. Reads are combinational from the current address, and writes take effect at the clock edge where `bus_wr` is high.

Top module: `ipi_regblk`

## Requirements
- R1: After reset the status register reads 0, the mask register reads 0x0F0F0301 (every channel masked), and `irq`, `trig_out` and `obs_out` are all zero.
- R2: Lane k (k = 0..10) sits at bus bit 0, 8, 9, 16, 17, 18, 19, 24, 25, 26, 27 respectively. Every other bit of every register reads as zero. A write that sets only such bits changes no state and fires no trigger.
- R3: A write to word offset 0x00 produces a pulse on `trig_out` that lasts exactly one clock. The pulse is high on the lanes whose bits were written as one, in the cycle after the write edge. Offset 0x00 reads as zero.
- R4: The mask register sits at offset 0x14 and is read-only. Writing ones to offset 0x18 clears the matching mask bits. Writing ones to offset 0x1C sets them. Offsets 0x18 and 0x1C read as zero.
- R5: The status register sits at offset 0x10. A one on `db_in[k]` at a clock edge sets status lane k. Writing a one to a status bit clears it. Writing a zero to a status bit leaves it unchanged.
- R6: If a doorbell on lane k and a write clearing lane k arrive at the same edge, the status bit stays set.
- R7: `irq` is high exactly when some lane is set in the status register and clear in the mask register.
- R8: Offset 0x04 is read-only. Each of its lane bits shows the level `obs_in` had at the most recent clock edge.
- R9: `obs_out[k]` equals status lane k at all times.
- R10: A read of an unmapped or non-word-aligned address returns zero. A write to such an address changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled at the rising edge |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current address |
| db_in | input | 11 | Inbound doorbell request per lane |
| obs_in | input | 11 | Pending level reported by each target agent |
| trig_out | output | 11 | Outbound doorbell pulse per lane |
| obs_out | output | 11 | This block's pending status per lane |
| irq | output | 1 | Combined interrupt to the local processor |

## Verification
A wrong status bit shows on `obs_out` in the cycle after the edge that produced it. It also shows on `irq` as soon as that lane is unmasked, so status faults are visible within one clock of the event. A wrong mask bit cannot be seen until a doorbell lands on that lane, so the tests pair each mask change with a latched doorbell and watch `irq` immediately afterwards. A lane swapped in the sparse bit mapping appears only when a read returns the bit at the wrong position, so every register is read back with asymmetric lane patterns.

// File: rtl/ipi_pkg.sv
`timescale 1ns/1ps
package ipi_pkg;
  localparam int NCH   = 11;
  localparam int REG_W = 32;

  // lane k lives at bus bit lane_pos(k); all other bits are reserved
  localparam logic [REG_W-1:0] LANE_MASK = 32'h0F0F_0301;

  // word indices (byte offset / 4)
  localparam int IDX_TRIG = 0;
  localparam int IDX_OBS  = 1;
  localparam int IDX_ISR  = 4;
  localparam int IDX_IMR  = 5;
  localparam int IDX_IER  = 6;
  localparam int IDX_IDR  = 7;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_TRIG, SEL_OBS, SEL_STAT, SEL_MASK, SEL_UNMASK, SEL_DOMASK
  } reg_sel_e;

  function automatic int lane_pos(input int k);
    case (k)
      0:       return 0;
      1:       return 8;
      2:       return 9;
      3:       return 16;
      4:       return 17;
      5:       return 18;
      6:       return 19;
      7:       return 24;
      8:       return 25;
      9:       return 26;
      default: return 27;
    endcase
  endfunction
endpackage

// File: rtl/ipi_lane_spread.sv
`timescale 1ns/1ps
module ipi_lane_spread
  import ipi_pkg::*;
(
  input  logic [NCH-1:0]   lanes,
  output logic [REG_W-1:0] word
);
  always_comb begin
    word = '0;
    for (int k = 0; k < NCH; k++) begin
      word[lane_pos(k)] = lanes[k];
    end
  end
endmodule

// File: rtl/ipi_trig_gen.sv
`timescale 1ns/1ps
module ipi_trig_gen
  import ipi_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           fire,
  input  logic [NCH-1:0] lanes,
  output logic [NCH-1:0] pulse
);
  logic [NCH-1:0] pulse_d, pulse_q;

  // a pulse is never held: next state is zero unless a write fires
  always_comb begin
    pulse_d = fire ? lanes : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_q <= '0;
    else        pulse_q <= pulse_d;
  end

  assign pulse = pulse_q;
endmodule

// File: rtl/ipi_mask_status.sv
`timescale 1ns/1ps
module ipi_mask_status
  import ipi_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] db_in,
  input  logic           clr_en,
  input  logic           unmask_en,
  input  logic           mask_en,
  input  logic [NCH-1:0] lanes,
  output logic [NCH-1:0] isr,
  output logic [NCH-1:0] imr
);
  logic [NCH-1:0] isr_d, isr_q, imr_d, imr_q;
  logic [NCH-1:0] clr_bits;
  logic           imr_ce;

  always_comb begin
    clr_bits = clr_en ? lanes : '0;
    // set after clear: an arriving doorbell beats a same-edge clear
    isr_d    = (isr_q & ~clr_bits) | db_in;
    imr_ce   = unmask_en | mask_en;
    imr_d    = imr_q;
    if (unmask_en)    imr_d = imr_q & ~lanes;
    else if (mask_en) imr_d = imr_q | lanes;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) isr_q <= '0;
    else        isr_q <= isr_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      imr_q <= '1;
    else if (imr_ce) imr_q <= imr_d;
  end

  assign isr = isr_q;
  assign imr = imr_q;
endmodule

// File: rtl/ipi_regblk.sv
`timescale 1ns/1ps
module ipi_regblk
  import ipi_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic [NCH-1:0]    db_in,
  input  logic [NCH-1:0]    obs_in,
  output logic [NCH-1:0]    trig_out,
  output logic [NCH-1:0]    obs_out,
  output logic              irq
);
  localparam int SEL_W = ADDR_W - 2;

  reg_sel_e       sel;
  logic [NCH-1:0] wlanes, rd_lanes;
  logic [NCH-1:0] obs_d, obs_q;
  logic [NCH-1:0] isr_q, imr_q;
  logic           we_trig, we_stat, we_unmask, we_domask;

  // address decode: only word-aligned mapped offsets select a register
  always_comb begin
    sel = SEL_NONE;
    if (bus_addr[1:0] == 2'b00) begin
      case (bus_addr[ADDR_W-1:2])
        SEL_W'(IDX_TRIG): sel = SEL_TRIG;
        SEL_W'(IDX_OBS):  sel = SEL_OBS;
        SEL_W'(IDX_ISR):  sel = SEL_STAT;
        SEL_W'(IDX_IMR):  sel = SEL_MASK;
        SEL_W'(IDX_IER):  sel = SEL_UNMASK;
        SEL_W'(IDX_IDR):  sel = SEL_DOMASK;
        default:          sel = SEL_NONE;
      endcase
    end
  end

  // gather the sparse write bits into compact lanes
  for (genvar k = 0; k < NCH; k++) begin : g_gather
    assign wlanes[k] = bus_wdata[lane_pos(k)];
  end

  assign we_trig   = bus_wr && (sel == SEL_TRIG);
  assign we_stat   = bus_wr && (sel == SEL_STAT);
  assign we_unmask = bus_wr && (sel == SEL_UNMASK);
  assign we_domask = bus_wr && (sel == SEL_DOMASK);

  ipi_trig_gen u_trig (
    .clk   (clk),
    .rst_n (rst_n),
    .fire  (we_trig),
    .lanes (wlanes),
    .pulse (trig_out)
  );

  ipi_mask_status u_stat (
    .clk       (clk),
    .rst_n     (rst_n),
    .db_in     (db_in),
    .clr_en    (we_stat),
    .unmask_en (we_unmask),
    .mask_en   (we_domask),
    .lanes     (wlanes),
    .isr       (isr_q),
    .imr       (imr_q)
  );

  // target pending levels are sampled every clock
  always_comb obs_d = obs_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) obs_q <= '0;
    else        obs_q <= obs_d;
  end

  always_comb begin
    case (sel)
      SEL_OBS:  rd_lanes = obs_q;
      SEL_STAT: rd_lanes = isr_q;
      SEL_MASK: rd_lanes = imr_q;
      default:  rd_lanes = '0;
    endcase
  end

  ipi_lane_spread u_spread (
    .lanes (rd_lanes),
    .word  (bus_rdata)
  );

  assign obs_out = isr_q;
  assign irq     = |(isr_q & ~imr_q);
endmodule

// File: rtl/ipi_regblk_chk.sv
`timescale 1ns/1ps
module ipi_regblk_chk
  import ipi_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [REG_W-1:0]  bus_wdata,
  input logic [REG_W-1:0]  bus_rdata,
  input logic [NCH-1:0]    db_in,
  input logic [NCH-1:0]    trig_out,
  input logic [NCH-1:0]    obs_out,
  input logic              irq,
  input logic [NCH-1:0]    imr
);
  localparam int SEL_W = ADDR_W - 2;

  logic aligned, hit_trig, hit_stat, hit_maskport, data_has_lane;
  assign aligned       = (bus_addr[1:0] == 2'b00);
  assign hit_trig      = aligned && (bus_addr[ADDR_W-1:2] == SEL_W'(IDX_TRIG));
  assign hit_stat      = aligned && (bus_addr[ADDR_W-1:2] == SEL_W'(IDX_ISR));
  assign hit_maskport  = aligned && ((bus_addr[ADDR_W-1:2] == SEL_W'(IDX_IER)) ||
                                     (bus_addr[ADDR_W-1:2] == SEL_W'(IDX_IDR)));
  assign data_has_lane = |(bus_wdata & LANE_MASK);

  // R3: any outbound pulse traces back to a trigger write one edge earlier
  a_r3_trig_from_write: assert property (@(posedge clk) disable iff (!rst_n)
    (|trig_out) |-> $past(bus_wr && hit_trig && data_has_lane));

  // R6: every doorbell seen at an edge is latched, whatever the bus did
  a_r6_doorbell_wins: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((obs_out & $past(db_in)) == $past(db_in)));

  // R4: mask moves only after a write to one of its two ports
  a_r4_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(bus_wr && hit_maskport)) |-> $stable(imr));

  // R9: status outputs hold with no doorbell and no status write
  a_r9_obs_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && ($past(db_in) == '0) && !$past(bus_wr && hit_stat))
      |-> $stable(obs_out));

  // R7: no unmasked pending lane means no interrupt
  a_r7_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ((obs_out & ~imr) == '0) |-> !irq);

  // R2: reserved positions never read as one
  a_r2_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rdata & ~LANE_MASK) == '0);
endmodule

bind ipi_regblk ipi_regblk_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .db_in     (db_in),
  .trig_out  (trig_out),
  .obs_out   (obs_out),
  .irq       (irq),
  .imr       (imr_q)
);

// File: tb/ipi_regblk_tb.sv
`timescale 1ns/1ps
module ipi_regblk_tb;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          bus_wr;
  logic [AW-1:0] bus_addr;
  logic [31:0]   bus_wdata;
  logic [31:0]   bus_rdata;
  logic [10:0]   db_in, obs_in, trig_out, obs_out;
  logic          irq;

  int vec = 0;
  int bad = 0;
  logic [10:0] trig_snap;
  logic [31:0] rd;

  ipi_regblk #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .db_in(db_in),
    .obs_in(obs_in), .trig_out(trig_out), .obs_out(obs_out), .irq(irq)
  );

  always #2 clk = ~clk;

  // lane-to-bit placement taken from R2
  function automatic logic [31:0] spread(input logic [10:0] l);
    int pos [11] = '{0, 8, 9, 16, 17, 18, 19, 24, 25, 26, 27};
    logic [31:0] w = '0;
    for (int k = 0; k < 11; k++) w[pos[k]] = l[k];
    return w;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vec++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    trig_snap = trig_out;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rdreg(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; #1;
    d = bus_rdata;
  endtask

  task automatic ring(input logic [10:0] l);
    @(negedge clk); db_in = l;
    @(negedge clk); db_in = '0;
  endtask

  task automatic t_reset;
    rdreg(8'h10, rd); chk("R1 status", rd, 32'h0);
    rdreg(8'h14, rd); chk("R1 mask", rd, 32'h0F0F0301);
    chk("R1 irq", {31'h0, irq}, 32'h0);
    chk("R1 trig", {21'h0, trig_out}, 32'h0);
    chk("R1 obs_out", {21'h0, obs_out}, 32'h0);
  endtask

  task automatic t_trig;
    wr(8'h00, 32'h0F0F0301); chk("R3 all lanes pulse", {21'h0, trig_snap}, 32'h7FF);
    @(posedge clk); #1;      chk("R3 pulse one clock", {21'h0, trig_out}, 32'h0);
    wr(8'h00, 32'h01000100); chk("R3 lanes 1,7", {21'h0, trig_snap}, 32'h082);
    rdreg(8'h00, rd);        chk("R3 reads zero", rd, 32'h0);
  endtask

  task automatic t_reserved;
    wr(8'h18, 32'hF0F0FCFE);
    rdreg(8'h14, rd);        chk("R2 reserved unmask ignored", rd, 32'h0F0F0301);
    wr(8'h00, 32'hF0F0FCFE); chk("R2 reserved trig ignored", {21'h0, trig_snap}, 32'h0);
  endtask

  task automatic t_mask;
    wr(8'h18, 32'h00000101);
    rdreg(8'h14, rd); chk("R4 unmask lanes 0,1", rd, 32'h0F0F0200);
    rdreg(8'h18, rd); chk("R4 unmask port reads zero", rd, 32'h0);
    wr(8'h1C, 32'h00000100);
    rdreg(8'h14, rd); chk("R4 remask lane 1", rd, 32'h0F0F0300);
    rdreg(8'h1C, rd); chk("R4 mask port reads zero", rd, 32'h0);
    wr(8'h14, 32'h0);
    rdreg(8'h14, rd); chk("R4 mask register read-only", rd, 32'h0F0F0300);
    wr(8'h1C, 32'h0F0F0301);
  endtask

  task automatic t_status;
    ring(11'h401);
    rdreg(8'h10, rd); chk("R5 doorbells latched", rd, 32'h08000001);
    chk("R9 obs_out mirrors", {21'h0, obs_out}, 32'h401);
    wr(8'h10, 32'h0);
    rdreg(8'h10, rd); chk("R5 zero write keeps", rd, 32'h08000001);
    wr(8'h10, 32'h00000001);
    rdreg(8'h10, rd); chk("R5 clear lane 0", rd, 32'h08000000);
    chk("R9 obs_out after clear", {21'h0, obs_out}, 32'h400);
    wr(8'h10, 32'h08000000);
    rdreg(8'h10, rd); chk("R5 clear lane 10", rd, 32'h0);
  endtask

  task automatic t_race;
    ring(11'h008);
    @(negedge clk);
    db_in = 11'h008; bus_wr = 1'b1; bus_addr = 8'h10; bus_wdata = 32'h00010000;
    @(negedge clk);
    db_in = '0; bus_wr = 1'b0;
    rdreg(8'h10, rd); chk("R6 doorbell beats clear", rd, 32'h00010000);
    wr(8'h10, 32'h00010000);
    rdreg(8'h10, rd); chk("R6 later clear works", rd, 32'h0);
  endtask

  task automatic t_irq;
    ring(11'h010);
    #1 chk("R7 masked no irq", {31'h0, irq}, 32'h0);
    wr(8'h18, 32'h00020000);
    #1 chk("R7 unmasked irq", {31'h0, irq}, 32'h1);
    wr(8'h1C, 32'h00020000);
    #1 chk("R7 remasked quiet", {31'h0, irq}, 32'h0);
    wr(8'h18, 32'h00020000);
    wr(8'h10, 32'h00020000);
    #1 chk("R7 cleared quiet", {31'h0, irq}, 32'h0);
    wr(8'h1C, 32'h0F0F0301);
  endtask

  task automatic t_obs;
    @(negedge clk); obs_in = 11'h5A5;
    rdreg(8'h04, rd); chk("R8 obs lanes", rd, spread(11'h5A5));
    @(negedge clk); obs_in = 11'h25A;
    rdreg(8'h04, rd); chk("R8 obs follows", rd, spread(11'h25A));
    @(negedge clk); obs_in = '0;
    wr(8'h04, 32'hFFFFFFFF);
    rdreg(8'h04, rd); chk("R8 obs read-only", rd, 32'h0);
  endtask

  task automatic t_unmapped;
    rdreg(8'h08, rd); chk("R10 read 0x08", rd, 32'h0);
    rdreg(8'h20, rd); chk("R10 read 0x20", rd, 32'h0);
    rdreg(8'h15, rd); chk("R10 misaligned read", rd, 32'h0);
    wr(8'h19, 32'h0F0F0301);
    wr(8'h2C, 32'hFFFFFFFF);
    rdreg(8'h14, rd); chk("R10 mask untouched", rd, 32'h0F0F0301);
    wr(8'h02, 32'h0F0F0301); chk("R10 misaligned trig silent", {21'h0, trig_snap}, 32'h0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    db_in = '0; obs_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_trig;
    t_reserved;
    t_mask;
    t_status;
    t_race;
    t_irq;
    t_obs;
    t_unmapped;
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule